// File: doc/BRIEF.md
# Memory-to-Configuration-Port Image Streamer

This block pushes a stored partial configuration image out of an on-chip image memory and into a byte-wide slave parallel configuration port. It needs no processor. A requester places a slot number on `slot_sel` and pulses `start` for one cycle. The block then reads that slot's bytes in rising address order and puts one byte on `cfg_data` in every clock cycle. It qualifies each byte with active-low chip-select and write strobes. It also forwards an inverted copy of its own clock as the port's configuration clock, so the port samples each byte in the middle of its cycle.

The image memory is organised as equal slots. Each slot holds `BLOCKS_PER_SLOT` memory blocks of `BLOCK_BYTES` bytes each, so the base address of a slot is its index times the slot size. Each slot has its own image length, set by a parameter. The memory sits beside the block, behind a synchronous read port with one cycle of latency. The block hides that latency with a single priming cycle.

A mode input, `stall_en`, decides how the port's busy line is treated. When the input is low, the busy line is ignored and the block sends a byte in every cycle. When the input is high, a high busy line freezes the sequence and keeps the current byte on the bus until busy falls. One cycle after the last byte, `xfer_done` pulses for a single cycle and the block returns to idle.

Top module: `cfg_image_streamer`

## Requirements
- R1: During and after reset, before any start, `cfg_cs_n` and `cfg_wr_n` are 1, `xfer_done` is 0, `mem_rd_en` is 0 and `cfg_data` is 0.
- R2: The strobes stay high in the cycle in which `start` is high (the priming cycle). The first byte of the image is on the bus, with both strobes low, in the cycle after the clock edge that samples `start`.
- R3: During a transfer, byte k of the image (k = 0, 1, …) sits on `cfg_data` with both strobes low, and a new byte follows in each cycle that is not stalled.
- R4: The first byte sent comes from memory address slot × `BLOCKS_PER_SLOT` × `BLOCK_BYTES`. With the defaults this is slot × 192, and four slots are available.
- R5: A transfer sends exactly the slot's length in bytes, taken from `SLOT_LEN` (16 bits per slot, with slot 0 in the low bits). The defaults are 192, 100, 5 and 1 for slots 0 to 3. The strobes rise in the cycle right after the final byte.
- R6: `xfer_done` is high for exactly one cycle: the cycle right after the final byte, during which the strobes are already high.
- R7: A `start` that arrives while a transfer is running is ignored. The running image goes on unchanged and ends after its own length.
- R8: With `stall_en` = 0, the level of `cfg_busy` has no effect, and an image of N bytes takes exactly N bus cycles.
- R9: With `stall_en` = 1, each cycle in which `cfg_busy` is high during a transfer repeats the current byte in the next cycle, with the strobes still low. This also applies to the final byte, whose `xfer_done` is delayed by the stall.
- R10: A `start` given in the `xfer_done` cycle is accepted, and the new image's first byte follows in the next cycle.
- R11: `cfg_cclk` is the inverse of `clk`.
- R12: `cfg_cs_n` and `cfg_wr_n` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one byte per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to stream the selected slot |
| slot_sel | input | 2 | Image slot index, sampled with `start` |
| stall_en | input | 1 | 1: obey `cfg_busy`; 0: ignore it |
| cfg_busy | input | 1 | Busy/wait line from the configuration port |
| mem_addr | output | 10 | Image memory read address |
| mem_rd_en | output | 1 | Image memory read enable |
| mem_rdata | input | 8 | Image memory read data, one cycle after the address |
| cfg_data | output | 8 | Configuration port data bus |
| cfg_cs_n | output | 1 | Active-low chip-select |
| cfg_wr_n | output | 1 | Active-low write strobe |
| cfg_cclk | output | 1 | Configuration clock for the port (inverted `clk`) |
| xfer_done | output | 1 | One-cycle pulse after the final byte |

## Verification
The hardest collision is a busy stall on the final byte. When it happens, the hold must win over the finish, so the last byte is sent twice and `xfer_done` moves one cycle later. The bench provokes this by raising `cfg_busy` exactly while the last byte of a five-byte slot is on the bus. It then checks that the same byte is still presented with the strobes low, that the cycle count is the length plus one, and that the done pulse comes only after the repeat. A second collision puts a new `start` in the same cycle as the done pulse. The bench judges it by requiring the next image's first byte in the very next cycle, with no idle cycle in between.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

    typedef logic [7:0] cfg_byte_t;

endpackage

// File: rtl/cfgs_slot_map.sv
module cfgs_slot_map #(
    parameter int NUM_SLOTS  = 4,
    parameter int SLOT_BYTES = 192,
    parameter int ADDR_W     = 10,
    parameter int LEN_W      = 16,
    parameter int SEL_W      = 2,
    parameter logic [NUM_SLOTS*LEN_W-1:0] SLOT_LEN = '0
) (
    input  logic [SEL_W-1:0]  slot_sel,
    output logic              slot_ok,
    output logic [ADDR_W-1:0] slot_base,
    output logic [LEN_W-1:0]  slot_len
);

    logic [ADDR_W-1:0] base_tab [NUM_SLOTS];
    logic [LEN_W-1:0]  len_tab  [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign base_tab[s] = ADDR_W'(s * SLOT_BYTES);
        assign len_tab[s]  = SLOT_LEN[s*LEN_W +: LEN_W];
    end

    always_comb begin
        slot_ok   = (int'(slot_sel) < NUM_SLOTS);
        slot_base = '0;
        slot_len  = '0;
        if (slot_ok) begin
            slot_base = base_tab[slot_sel];
            slot_len  = len_tab[slot_sel];
        end
    end

endmodule

// File: rtl/cfgs_seq.sv
module cfgs_seq
    import cfgs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              slot_ok,
    input  logic [ADDR_W-1:0] slot_base,
    input  logic [LEN_W-1:0]  slot_len,
    input  logic              stall_en,
    input  logic              busy,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en,
    output logic              active,
    output logic              done
);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic              done;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;
    logic      hold;
    logic      last;

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        hold        = stall_en && busy;
        last        = (regs_q.cnt == regs_q.len - 1'b1);
        case (regs_q.state)
            ST_IDLE: begin
                if (start && slot_ok) begin
                    regs_d.state = ST_XFER;
                    regs_d.addr  = slot_base;
                    regs_d.cnt   = '0;
                    regs_d.len   = slot_len;
                end
            end
            ST_XFER: begin
                if (!hold) begin
                    if (last) begin
                        regs_d.state = ST_IDLE;
                        regs_d.done  = 1'b1;
                    end else begin
                        regs_d.addr = regs_q.addr + 1'b1;
                        regs_d.cnt  = regs_q.cnt + 1'b1;
                    end
                end
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, addr: '0, cnt: '0, len: '0, done: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    // Address issued one cycle ahead so read data lines up with the bus cycle
    assign rd_addr = regs_d.addr;
    assign rd_en   = (regs_d.state == ST_XFER);
    assign active  = (regs_q.state == ST_XFER);
    assign done    = regs_q.done;

endmodule

// File: rtl/cfgs_port_drv.sv
module cfgs_port_drv
    import cfgs_pkg::*;
(
    input  logic      clk,
    input  logic      active,
    input  cfg_byte_t rd_data,
    output cfg_byte_t cfg_data,
    output logic      cfg_cs_n,
    output logic      cfg_wr_n,
    output logic      cfg_cclk
);

    always_comb begin
        cfg_data = active ? rd_data : '0;
        cfg_cs_n = !active;
        cfg_wr_n = !active;
    end

    // Port samples on its rising edge, i.e. mid-cycle of the local clock
    assign cfg_cclk = ~clk;

endmodule

// File: rtl/cfg_image_streamer.sv
module cfg_image_streamer
    import cfgs_pkg::*;
#(
    parameter int BLOCK_BYTES     = 64,
    parameter int BLOCKS_PER_SLOT = 3,
    parameter int NUM_SLOTS       = 4,
    parameter int LEN_W           = 16,
    parameter logic [NUM_SLOTS*LEN_W-1:0] SLOT_LEN = {16'd1, 16'd5, 16'd100, 16'd192},
    localparam int SLOT_BYTES = BLOCK_BYTES * BLOCKS_PER_SLOT,
    localparam int MEM_BYTES  = SLOT_BYTES * NUM_SLOTS,
    localparam int ADDR_W     = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1,
    localparam int SEL_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  slot_sel,
    input  logic              stall_en,
    input  logic              cfg_busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        cfg_data,
    output logic              cfg_cs_n,
    output logic              cfg_wr_n,
    output logic              cfg_cclk,
    output logic              xfer_done
);

    logic              slot_ok;
    logic [ADDR_W-1:0] slot_base;
    logic [LEN_W-1:0]  slot_len;
    logic              active;

    cfgs_slot_map #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_BYTES(SLOT_BYTES),
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .SEL_W     (SEL_W),
        .SLOT_LEN  (SLOT_LEN)
    ) map_i (
        .slot_sel (slot_sel),
        .slot_ok  (slot_ok),
        .slot_base(slot_base),
        .slot_len (slot_len)
    );

    cfgs_seq #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .slot_ok  (slot_ok),
        .slot_base(slot_base),
        .slot_len (slot_len),
        .stall_en (stall_en),
        .busy     (cfg_busy),
        .rd_addr  (mem_addr),
        .rd_en    (mem_rd_en),
        .active   (active),
        .done     (xfer_done)
    );

    cfgs_port_drv drv_i (
        .clk     (clk),
        .active  (active),
        .rd_data (mem_rdata),
        .cfg_data(cfg_data),
        .cfg_cs_n(cfg_cs_n),
        .cfg_wr_n(cfg_wr_n),
        .cfg_cclk(cfg_cclk)
    );

endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              stall_en,
    input logic              cfg_busy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_en,
    input logic [7:0]        cfg_data,
    input logic              cfg_cs_n,
    input logic              cfg_wr_n,
    input logic              xfer_done
);

    a_r12_strobes_match: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cs_n == cfg_wr_n);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    a_r6_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (cfg_cs_n && $past(!cfg_cs_n)));

    a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_en && cfg_busy && !cfg_cs_n) |=> (!cfg_cs_n && $stable(cfg_data) && !xfer_done));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !cfg_cs_n && !(stall_en && cfg_busy))
            |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cfg_cs_n && mem_rd_en) |=> !cfg_cs_n);

endmodule

bind cfg_image_streamer cfgs_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stall_en (stall_en),
    .cfg_busy (cfg_busy),
    .mem_addr (mem_addr),
    .mem_rd_en(mem_rd_en),
    .cfg_data (cfg_data),
    .cfg_cs_n (cfg_cs_n),
    .cfg_wr_n (cfg_wr_n),
    .xfer_done(xfer_done)
);

// File: tb/cfg_image_streamer_tb_top.sv
module cfg_image_streamer_tb_top;

    localparam int SLOTB = 192;
    localparam int MEMB  = 768;
    localparam int LENS [4] = '{192, 100, 5, 1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] slot_sel = '0;
    logic       stall_en = 1'b0;
    logic       cfg_busy = 1'b0;
    logic [9:0] mem_addr;
    logic       mem_rd_en;
    logic [7:0] mem_rdata = '0;
    logic [7:0] cfg_data;
    logic       cfg_cs_n, cfg_wr_n, cfg_cclk, xfer_done;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    cfg_image_streamer #(
        .SLOT_LEN({16'd1, 16'd5, 16'd100, 16'd192})
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .slot_sel(slot_sel),
        .stall_en(stall_en), .cfg_busy(cfg_busy), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .cfg_data(cfg_data),
        .cfg_cs_n(cfg_cs_n), .cfg_wr_n(cfg_wr_n), .cfg_cclk(cfg_cclk),
        .xfer_done(xfer_done)
    );

    function automatic logic [7:0] img(input int a);
        return 8'((a * 37 + (a >> 6) + 11) & 255);
    endfunction

    logic [7:0] mem [MEMB];
    initial begin
        for (int a = 0; a < MEMB; a++) mem[a] = img(a);
    end

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic launch(input int slot);
        chk(cfg_cs_n == 1'b1, "R2", "strobe high in priming cycle", cfg_cs_n, 1);
        slot_sel = 2'(slot);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic body(input int slot, input bit stall, input int busy_every,
                        input bit hold_last, input int poke_at, input string req);
        int len = LENS[slot];
        int base = slot * SLOTB;
        int i = 0;
        int cyc = 0;
        int stalls = 0;
        bit held = 1'b0;
        bit b;
        stall_en = stall;
        while (i < len && cyc < 2000) begin
            chk(!cfg_cs_n && !cfg_wr_n, req, "strobes low",
                int'({cfg_cs_n, cfg_wr_n}), 0);
            chk(cfg_data == img(base + i), req, "byte", cfg_data, img(base + i));
            b = (busy_every > 0 && (cyc % busy_every) == 0) ||
                (hold_last && i == len - 1 && !held);
            if (hold_last && i == len - 1) held = 1'b1;
            cfg_busy = b;
            start = (cyc == poke_at);
            @(negedge clk);
            if (b && stall) stalls++;
            else i++;
            cyc++;
        end
        cfg_busy = 1'b0;
        start = 1'b0;
        chk(cyc == len + stalls, "R5", "bus cycles", cyc, len + stalls);
        chk(xfer_done == 1'b1, "R6", "done after final byte", xfer_done, 1);
        chk(cfg_cs_n == 1'b1 && cfg_wr_n == 1'b1, "R5", "strobes released",
            int'({cfg_cs_n, cfg_wr_n}), 3);
    endtask

    task automatic tail();
        @(negedge clk);
        chk(xfer_done == 1'b0, "R6", "done lasts one cycle", xfer_done, 0);
        chk(cfg_cs_n == 1'b1, "R6", "idle strobes", cfg_cs_n, 1);
        chk(mem_rd_en == 1'b0, "R6", "reads stop", mem_rd_en, 0);
    endtask

    task automatic t_r1_reset();
        @(negedge clk);
        chk(cfg_cs_n && cfg_wr_n, "R1", "strobes in reset", int'({cfg_cs_n, cfg_wr_n}), 3);
        chk(!xfer_done && !mem_rd_en, "R1", "done/rd in reset",
            int'({xfer_done, mem_rd_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(cfg_cs_n && cfg_wr_n && !xfer_done, "R1", "idle after reset",
            int'({cfg_cs_n, cfg_wr_n, xfer_done}), 6);
        chk(cfg_data == 8'd0, "R1", "idle bus", cfg_data, 0);
    endtask

    task automatic t_r5_single();
        launch(3);
        body(3, 1'b0, 0, 1'b0, -1, "R5");
        tail();
    endtask

    task automatic t_r4_short();
        launch(2);
        body(2, 1'b0, 0, 1'b0, -1, "R4");
        tail();
    endtask

    task automatic t_r8_busy_ignored();
        launch(0);
        body(0, 1'b0, 2, 1'b0, -1, "R8");
        tail();
    endtask

    task automatic t_r9_stall();
        launch(1);
        body(1, 1'b1, 3, 1'b0, -1, "R9");
        tail();
    endtask

    task automatic t_r9_last_byte_hold();
        launch(2);
        body(2, 1'b1, 0, 1'b1, -1, "R9");
        tail();
    endtask

    task automatic t_r7_restart_ignored();
        launch(1);
        body(1, 1'b0, 0, 1'b0, 10, "R7");
        tail();
    endtask

    task automatic t_r10_chain();
        launch(3);
        body(3, 1'b0, 0, 1'b0, -1, "R3");
        launch(2);
        body(2, 1'b0, 0, 1'b0, -1, "R10");
        tail();
        launch(0);
        body(0, 1'b0, 0, 1'b0, -1, "R3");
        tail();
    endtask

    task automatic t_r11_cclk();
        @(negedge clk);
        #1;
        chk(cfg_cclk == 1'b1, "R11", "cclk while clk low", cfg_cclk, 1);
        @(posedge clk);
        #1;
        chk(cfg_cclk == 1'b0, "R11", "cclk while clk high", cfg_cclk, 0);
        chk(cfg_cs_n == cfg_wr_n, "R12", "strobes equal", cfg_wr_n, cfg_cs_n);
    endtask

    initial begin
        t_r1_reset();
        t_r5_single();
        t_r4_short();
        t_r8_busy_ignored();
        t_r9_stall();
        t_r9_last_byte_hold();
        t_r7_restart_ignored();
        t_r10_chain();
        t_r11_cclk();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule